// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a segment-relative reference into a flat 32-bit address. It keeps six segment slots. Software places a 16-bit selector into a slot. The unit then finds the matching descriptor in one of two in-memory tables, reads it once over a simple read port, and keeps a private copy of its base, its limit and its presence flag. From then on, every reference through that slot is checked and translated from the stored copy alone. No further memory traffic is needed.

A reference gives a slot number and a 32-bit offset. One cycle later the unit reports one of two results:
- a fault code, or
- the linear address, which is the segment base plus the offset.

While paging is switched off, the linear address is also offered as the physical address.

Descriptor layout in the 64-bit read word:
- bits 31:0 hold the base.
- bits 51:32 hold the 20-bit limit.
- bit 52 is the page-granularity flag.
- bit 53 is the present flag.

Fault codes:
- 0: none
- 1: unusable slot
- 2: segment absent
- 3: offset over the limit

Top module: `segXlate`

## Requirements
- R1: After reset all six slots are unusable, `ldBusy`, `ldDone` and `accOutValid` are 0, and a reference to any slot reports fault code 1.
- R2: Selector bit 2 picks the table: 0 selects the global table (base `globalTblBase`, entry count `globalTblCnt`), and 1 selects the local table (`localTblBase`, `localTblCnt`).
- R3: The descriptor read address is the chosen table base plus the selector with its low three bits cleared. `memRdReq` stays high with a stable `memRdAddr` until `memRdAck`.
- R4: The descriptor is read only when a selector is loaded. `ldDone` rises in the cycle after the edge that samples `memRdAck`, and references never cause a memory read.
- R5: A selector whose bits 15:2 are all zero loads without any memory read. It gives `ldDone` in the cycle after the request, and it leaves the slot unusable, so references then report code 1.
- R6: A selector whose index (bits 15:3) is equal to or above the chosen table's entry count gives `ldDone` together with `ldFault` after one cycle. It makes no memory read and leaves the slot's previous contents in effect.
- R7: A reference through a slot whose descriptor has the present bit clear reports code 2.
- R8: With the granularity bit clear, the effective limit is the 20-bit limit in bytes. An offset equal to the limit passes, and an offset greater than it reports code 3.
- R9: With the granularity bit set, the effective limit is the 20-bit limit followed by twelve one bits.
- R10: `accOutValid` follows `accValid` by one cycle. Without a fault, `accLinear` is base plus offset modulo 2^32; with a fault, it is zero.
- R11: `physValid` is high exactly when a result is valid, has no fault and `pagingOn` is 0. In that case `physAddr` equals `accLinear`.
- R12: A load request that arrives while `ldBusy` is high is ignored.
- R13: Fault priority is unusable, then absent, then limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pagingOn | input | 1 | Paging enabled; suppresses the physical output |
| localTblBase | input | 32 | Local descriptor table base address |
| localTblCnt | input | 14 | Local table entry count |
| globalTblBase | input | 32 | Global descriptor table base address |
| globalTblCnt | input | 14 | Global table entry count |
| ldValid | input | 1 | Selector load request |
| ldReg | input | 3 | Slot to load (0..5) |
| ldSel | input | 16 | Selector value |
| ldBusy | output | 1 | Descriptor fetch in progress |
| ldDone | output | 1 | One-cycle load completion pulse |
| ldFault | output | 1 | Load rejected (index out of table) |
| memRdReq | output | 1 | Descriptor read request |
| memRdAddr | output | 32 | Descriptor read address |
| memRdAck | input | 1 | Read data valid |
| memRdData | input | 64 | Descriptor word |
| accValid | input | 1 | Reference request |
| accReg | input | 3 | Slot used by the reference |
| accOffset | input | 32 | Offset within the segment |
| accOutValid | output | 1 | Reference result valid |
| accFault | output | 1 | Reference faulted |
| accFaultKind | output | 2 | Fault code (0..3) |
| accLinear | output | 32 | Linear address, zero on fault |
| physValid | output | 1 | Physical address valid |
| physAddr | output | 32 | Physical address when paging is off |

## Verification
The checker takes for granted the following about the inputs:
- Slot numbers on both the load and the reference side stay below six.
- `memRdAck` is raised only while a read is pending.
- `memRdData` is valid only in the acknowledge cycle.

The bench keeps within these rules:
- Its memory model answers only a pending request, after two cycles, with a single-cycle acknowledge.
- All slot numbers it drives are in 0..5.
- `pagingOn` changes only between references, so the physical output is judged against a steady mode.

// File: rtl/segPkg.sv
package segPkg;
  parameter int SEG_CNT = 6;
  parameter int SEL_W   = 16;
  parameter int ADDR_W  = 32;
  parameter int LIM_W   = 20;
  parameter int PG_SH   = 12;
  parameter int DESC_W  = 64;

  localparam int IDX_W = SEL_W - 3;
  localparam int CNT_W = IDX_W + 1;
  localparam int REG_W = $clog2(SEG_CNT);

  // descriptor word layout
  localparam int D_BASE_LSB = 0;
  localparam int D_LIM_LSB  = 32;
  localparam int D_GRAN_BIT = 52;
  localparam int D_PRES_BIT = 53;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_UNUSABLE = 2'd1,
    FLT_ABSENT   = 2'd2,
    FLT_LIMIT    = 2'd3
  } fltKind_t;

  typedef struct packed {
    logic             cacheWr;   // latch fetched descriptor
    logic             markNull;  // make slot unusable
    logic [REG_W-1:0] tgtReg;
  } ctrlStrb_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] localTblBase,
  input  logic [CNT_W-1:0]  localTblCnt,
  input  logic [ADDR_W-1:0] globalTblBase,
  input  logic [CNT_W-1:0]  globalTblCnt,
  input  logic              ldValid,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [SEL_W-1:0]  ldSel,
  output logic              ldBusy,
  output logic              ldDone,
  output logic              ldFault,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  output ctrlStrb_t         strb
);
  typedef enum logic {ST_IDLE, ST_FETCH} state_t;
  state_t stateQ;
  logic [REG_W-1:0] pendReg;

  logic              useLocal, isNull, outOfRange, takeLoad;
  logic [IDX_W-1:0]  selIdx;
  logic [CNT_W-1:0]  tblCnt;
  logic [ADDR_W-1:0] tblBase;

  always_comb begin
    useLocal   = ldSel[2];
    selIdx     = ldSel[SEL_W-1:3];
    tblCnt     = useLocal ? localTblCnt  : globalTblCnt;
    tblBase    = useLocal ? localTblBase : globalTblBase;
    isNull     = (ldSel[SEL_W-1:2] == '0);
    outOfRange = ({1'b0, selIdx} >= tblCnt);
    takeLoad   = (stateQ == ST_IDLE) && ldValid;
  end

  always_comb begin
    strb.cacheWr  = (stateQ == ST_FETCH) && memRdAck;
    strb.markNull = takeLoad && isNull;
    strb.tgtReg   = (stateQ == ST_IDLE) ? ldReg : pendReg;
  end

  assign memRdReq = (stateQ == ST_FETCH);
  assign ldBusy   = (stateQ == ST_FETCH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      pendReg   <= '0;
      memRdAddr <= '0;
      ldDone    <= 1'b0;
      ldFault   <= 1'b0;
    end else begin
      ldDone  <= 1'b0;
      ldFault <= 1'b0;
      case (stateQ)
        ST_IDLE: if (ldValid) begin
          if (isNull) begin
            ldDone <= 1'b1;
          end else if (outOfRange) begin
            ldDone  <= 1'b1;
            ldFault <= 1'b1;
          end else begin
            stateQ    <= ST_FETCH;
            pendReg   <= ldReg;
            memRdAddr <= tblBase + ADDR_W'({selIdx, 3'b000});
          end
        end
        ST_FETCH: if (memRdAck) begin
          stateQ <= ST_IDLE;
          ldDone <= 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DESC_W-1:0] memRdData,
  input  logic              pagingOn,
  input  logic              accValid,
  input  logic [REG_W-1:0]  accReg,
  input  logic [ADDR_W-1:0] accOffset,
  output logic              accOutValid,
  output logic              accFault,
  output logic [1:0]        accFaultKind,
  output logic [ADDR_W-1:0] accLinear,
  output logic              physValid,
  output logic [ADDR_W-1:0] physAddr
);
  logic              usableQ  [SEG_CNT];
  logic              presentQ [SEG_CNT];
  logic [ADDR_W-1:0] baseQ    [SEG_CNT];
  logic [ADDR_W-1:0] effLimQ  [SEG_CNT];

  logic [ADDR_W-1:0] newBase, newEffLim;
  logic [LIM_W-1:0]  newLim;
  logic              newGran, newPres;

  always_comb begin
    newBase = memRdData[D_BASE_LSB +: ADDR_W];
    newLim  = memRdData[D_LIM_LSB +: LIM_W];
    newGran = memRdData[D_GRAN_BIT];
    newPres = memRdData[D_PRES_BIT];
  end

  // effective limit: page-scaled variant only when the scaled width fits
  generate
    if (LIM_W + PG_SH <= ADDR_W) begin : g_scaleFit
      always_comb newEffLim = newGran ? ADDR_W'({newLim, {PG_SH{1'b1}}})
                                      : ADDR_W'(newLim);
    end else begin : g_scaleClip
      always_comb newEffLim = newGran ? {ADDR_W{1'b1}} : ADDR_W'(newLim);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_CNT; i++) begin
        usableQ[i]  <= 1'b0;
        presentQ[i] <= 1'b0;
        baseQ[i]    <= '0;
        effLimQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < SEG_CNT; i++) begin
        if (strb.tgtReg == REG_W'(i)) begin
          if (strb.markNull) begin
            usableQ[i] <= 1'b0;
          end else if (strb.cacheWr) begin
            usableQ[i]  <= 1'b1;
            presentQ[i] <= newPres;
            baseQ[i]    <= newBase;
            effLimQ[i]  <= newEffLim;
          end
        end
      end
    end
  end

  logic              selUsable, selPres;
  logic [ADDR_W-1:0] selBase, selLim;
  fltKind_t          kindNext;

  always_comb begin
    selUsable = 1'b0;
    selPres   = 1'b0;
    selBase   = '0;
    selLim    = '0;
    if (accReg < REG_W'(SEG_CNT)) begin
      selUsable = usableQ[accReg];
      selPres   = presentQ[accReg];
      selBase   = baseQ[accReg];
      selLim    = effLimQ[accReg];
    end
    if (!selUsable)               kindNext = FLT_UNUSABLE;
    else if (!selPres)            kindNext = FLT_ABSENT;
    else if (accOffset > selLim)  kindNext = FLT_LIMIT;
    else                          kindNext = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOutValid  <= 1'b0;
      accFaultKind <= 2'd0;
      accLinear    <= '0;
    end else begin
      accOutValid <= accValid;
      if (accValid) begin
        accFaultKind <= kindNext;
        accLinear    <= (kindNext == FLT_NONE) ? selBase + accOffset : '0;
      end
    end
  end

  assign accFault  = (accFaultKind != 2'd0);
  assign physValid = accOutValid && !accFault && !pagingOn;
  assign physAddr  = pagingOn ? '0 : accLinear;
endmodule

// File: rtl/segXlate.sv
module segXlate
  import segPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pagingOn,
  input  logic [ADDR_W-1:0] localTblBase,
  input  logic [CNT_W-1:0]  localTblCnt,
  input  logic [ADDR_W-1:0] globalTblBase,
  input  logic [CNT_W-1:0]  globalTblCnt,
  input  logic              ldValid,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [SEL_W-1:0]  ldSel,
  output logic              ldBusy,
  output logic              ldDone,
  output logic              ldFault,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  input  logic [DESC_W-1:0] memRdData,
  input  logic              accValid,
  input  logic [REG_W-1:0]  accReg,
  input  logic [ADDR_W-1:0] accOffset,
  output logic              accOutValid,
  output logic              accFault,
  output logic [1:0]        accFaultKind,
  output logic [ADDR_W-1:0] accLinear,
  output logic              physValid,
  output logic [ADDR_W-1:0] physAddr
);
  ctrlStrb_t strb;

  segCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .localTblBase(localTblBase), .localTblCnt(localTblCnt),
    .globalTblBase(globalTblBase), .globalTblCnt(globalTblCnt),
    .ldValid(ldValid), .ldReg(ldReg), .ldSel(ldSel),
    .ldBusy(ldBusy), .ldDone(ldDone), .ldFault(ldFault),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdAck(memRdAck),
    .strb(strb)
  );

  segDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdData(memRdData),
    .pagingOn(pagingOn), .accValid(accValid), .accReg(accReg),
    .accOffset(accOffset), .accOutValid(accOutValid), .accFault(accFault),
    .accFaultKind(accFaultKind), .accLinear(accLinear),
    .physValid(physValid), .physAddr(physAddr)
  );
endmodule

// File: rtl/segXlateChk.sv
module segXlateChk
  import segPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              pagingOn,
  input logic              ldValid,
  input logic [REG_W-1:0]  ldReg,
  input logic              ldBusy,
  input logic              ldDone,
  input logic              ldFault,
  input logic              memRdReq,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memRdAck,
  input logic              accValid,
  input logic [REG_W-1:0]  accReg,
  input logic              accOutValid,
  input logic              accFault,
  input logic [ADDR_W-1:0] accLinear,
  input logic              physValid,
  input logic [ADDR_W-1:0] physAddr
);
  AST_ACC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> accOutValid); // R10
  AST_FAULT_ZERO_LIN: assert property (@(posedge clk) disable iff (!rstN)
    (accOutValid && accFault) |-> (accLinear == '0)); // R10
  AST_PHYS_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    physValid |-> (physAddr == accLinear && !pagingOn && !accFault)); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> (memRdReq && $stable(memRdAddr))); // R3
  AST_ACK_IN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    memRdAck |-> memRdReq); // R3
  AST_LDFAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ldFault |-> (ldDone && !ldBusy)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ldDone |-> !ldBusy); // R4
  AST_FETCH_ENDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && memRdAck) |=> ldDone); // R4
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid |-> accReg < REG_W'(SEG_CNT)) and
    (ldValid |-> ldReg < REG_W'(SEG_CNT))); // R1
endmodule

bind segXlate segXlateChk u_chk (.*);

// File: tb/sim_segXlate.sv
module sim_segXlate;
  import segPkg::*;

  logic clk = 1'b0, rstN = 1'b0, pagingOn = 1'b0;
  logic [31:0] localTblBase = 32'h0004_0000, globalTblBase = 32'h0008_0100;
  logic [13:0] localTblCnt = 14'd64, globalTblCnt = 14'd32;
  logic ldValid = 1'b0;
  logic [2:0] ldReg = '0;
  logic [15:0] ldSel = '0;
  logic ldBusy, ldDone, ldFault, memRdReq;
  logic [31:0] memRdAddr;
  logic memRdAck = 1'b0;
  logic [63:0] memRdData = '0;
  logic accValid = 1'b0;
  logic [2:0] accReg = '0;
  logic [31:0] accOffset = '0;
  logic accOutValid, accFault, physValid;
  logic [1:0] accFaultKind;
  logic [31:0] accLinear, physAddr;

  segXlate u0 (.*);

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0, readCnt = 0;
  logic [63:0] memDesc = '0;
  logic [31:0] lastAddr = '0;
  logic memWait = 1'b0;

  // memory model: answer a pending read after two cycles
  initial begin
    forever begin
      @(negedge clk);
      if (memRdAck) memRdAck = 1'b0;
      else if (memRdReq) begin
        if (memWait) begin
          memRdAck = 1'b1; memRdData = memDesc; lastAddr = memRdAddr;
          readCnt++; memWait = 1'b0;
        end else memWait = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  function automatic logic [63:0] mkDesc(logic [31:0] b, logic [19:0] l,
                                         logic g, logic p);
    return {10'b0, p, g, l, b};
  endfunction

  task automatic doLoad(input logic [2:0] r, input logic [15:0] s,
                        output int lat);
    @(negedge clk); ldValid = 1'b1; ldReg = r; ldSel = s;
    @(negedge clk); ldValid = 1'b0;
    lat = 0;
    while (!ldDone && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic doAccess(input logic [2:0] r, input logic [31:0] off);
    @(negedge clk); accValid = 1'b1; accReg = r; accOffset = off;
    @(negedge clk); accValid = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  slot;
    logic [15:0] sel;
    logic [31:0] base;
    logic [19:0] lim;
    logic        gran;
    logic        pres;
    logic [31:0] off;
    logic [1:0]  code;
    logic [31:0] lin;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 16'h0010, 32'h0010_0000, 20'h00FFF, 1'b0, 1'b1, 32'h0000_0FFF, 2'd0, 32'h0010_0FFF},
    '{3'd1, 16'h001F, 32'h2000_0000, 20'h00010, 1'b0, 1'b1, 32'h0000_0011, 2'd3, 32'h0},
    '{3'd2, 16'h0024, 32'hFFFF_F000, 20'h00003, 1'b1, 1'b1, 32'h0000_3FFF, 2'd0, 32'h0000_2FFF},
    '{3'd3, 16'h0028, 32'h1234_0000, 20'h00003, 1'b1, 1'b1, 32'h0000_4000, 2'd3, 32'h0},
    '{3'd4, 16'h0030, 32'h0000_8000, 20'hFFFFF, 1'b0, 1'b0, 32'h0000_0000, 2'd2, 32'h0},
    '{3'd5, 16'h00F8, 32'h0ABC_0000, 20'hFFFFF, 1'b1, 1'b1, 32'hFFFF_FFFF, 2'd0, 32'h0ABB_FFFF}
  };

  initial begin
    int lat, rc;
    logic [31:0] expAddr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!ldBusy && !ldDone && !accOutValid, "R1", "idle outputs after reset",
          {ldBusy, ldDone, accOutValid}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      doAccess(3'(i), 32'h0);
      check(accOutValid && accFaultKind == 2'd1, "R1", "slot unusable after reset",
            accFaultKind, 1);
    end

    // vector walk: R2 R3 R4 R7 R8 R9 R10 R11
    for (int v = 0; v < 6; v++) begin
      memDesc = mkDesc(VEC[v].base, VEC[v].lim, VEC[v].gran, VEC[v].pres);
      rc = readCnt;
      doLoad(VEC[v].slot, VEC[v].sel, lat);
      expAddr = (VEC[v].sel[2] ? localTblBase : globalTblBase) +
                {16'h0, VEC[v].sel[15:3], 3'b000};
      check(lastAddr == expAddr && readCnt == rc + 1, "R3", "descriptor address (R2 table pick)",
            lastAddr, expAddr);
      check(lat == 2 && !ldFault, "R4", "load latency", lat, 2);
      rc = readCnt;
      doAccess(VEC[v].slot, VEC[v].off);
      check(accFaultKind == VEC[v].code, "R8", "fault code (R7/R9 cases)",
            accFaultKind, VEC[v].code);
      check(accLinear == VEC[v].lin, "R10", "linear address", accLinear, VEC[v].lin);
      check(physValid == (VEC[v].code == 2'd0) &&
            (!physValid || physAddr == VEC[v].lin), "R11", "physical output",
            {physValid, physAddr}, {VEC[v].code == 2'd0, VEC[v].lin});
      check(readCnt == rc, "R4", "no memory read on reference", readCnt, rc);
    end

    // R8: offset exactly at byte limit passes, one over faults
    doAccess(3'd1, 32'h10);
    check(accFaultKind == 2'd0 && accLinear == 32'h2000_0010, "R8", "offset equal to limit",
          accLinear, 32'h2000_0010);
    // R9: page-granular limit 0x3FFF one over
    doAccess(3'd2, 32'h4000);
    check(accFaultKind == 2'd3, "R9", "page limit exceeded", accFaultKind, 3);

    // R6: index out of range, global and local
    rc = readCnt;
    doLoad(3'd0, 16'h0100, lat);
    check(ldDone && ldFault && lat == 0, "R6", "global index over count", {ldDone, ldFault}, 2'b11);
    doLoad(3'd0, 16'h0204, lat);
    check(ldDone && ldFault && lat == 0, "R6", "local index over count", {ldDone, ldFault}, 2'b11);
    check(readCnt == rc, "R6", "no read on rejected load", readCnt, rc);
    doAccess(3'd0, 32'h10);
    check(accFaultKind == 2'd0 && accLinear == 32'h0010_0010, "R6", "slot unchanged",
          accLinear, 32'h0010_0010);

    // R5: null selector (RPL bits nonzero)
    rc = readCnt;
    doLoad(3'd1, 16'h0003, lat);
    check(ldDone && !ldFault && lat == 0 && readCnt == rc, "R5", "null load no read",
          {lat[7:0], readCnt[7:0]}, {8'd0, rc[7:0]});
    // R13: unusable wins over limit; absent wins over limit
    doAccess(3'd1, 32'hFFFF_FFFF);
    check(accFaultKind == 2'd1, "R13", "unusable before limit", accFaultKind, 1);
    doAccess(3'd4, 32'hFFFF_FFFF);
    check(accFaultKind == 2'd2, "R13", "absent before limit", accFaultKind, 2);

    // R11: paging on suppresses physical output
    @(negedge clk); pagingOn = 1'b1;
    doAccess(3'd0, 32'h4);
    check(!physValid && accLinear == 32'h0010_0004, "R11", "paging on",
          {physValid, accLinear}, {1'b0, 32'h0010_0004});
    @(negedge clk); pagingOn = 1'b0;

    // R12: load request while busy is ignored
    memDesc = mkDesc(32'h0010_0000, 20'h00FFF, 1'b0, 1'b1);
    @(negedge clk); ldValid = 1'b1; ldReg = 3'd2; ldSel = 16'h0010;
    @(negedge clk); ldReg = 3'd0; ldSel = 16'h0000;
    check(ldBusy, "R12", "busy during fetch", ldBusy, 1);
    @(negedge clk); ldValid = 1'b0;
    lat = 0;
    while (!ldDone && lat < 20) begin @(negedge clk); lat++; end
    doAccess(3'd0, 32'h20);
    check(accFaultKind == 2'd0 && accLinear == 32'h0010_0020, "R12", "ignored load left slot",
          accLinear, 32'h0010_0020);
    doAccess(3'd2, 32'h10);
    check(accFaultKind == 2'd0 && accLinear == 32'h0010_0010, "R12", "first load took effect",
          accLinear, 32'h0010_0010);

    finishRun();
  end
endmodule